// File: doc/BRIEF.md
# Hitless Switching Bandwidth Sequencer

This block steers a clock PLL through the recovery that follows a loss-of-lock event, so that a reference change or a phase hit does not throw the output clock around. Once the loop has locked for the first time, the sequencer is armed. A rising loss-of-lock flag then starts the recovery, whatever the reference-selection mode is and whether or not any input mux moved. The sequencer first takes the phase detector out of the loop and forces the narrow loop bandwidth. If feedback phase build-out is enabled, it then asks the edge-selection logic to realign the feedback clock and waits for that to finish. After that it puts the phase detector back in the loop.

While the loop settles, the sequencer counts lock comparisons that fall inside the phase window. A run of `RUN_LEN` consecutive in-window comparisons starts a hold timer of `HOLD_CYCLES` system clocks. When the timer expires, the external bandwidth pin is in control again and the sequencer re-arms. Further loss-of-lock edges that arrive during recovery do nothing. The default `HOLD_CYCLES` of 44 covers 175 ns at a 250 MHz system clock.

Top module: `hitless_bw_seq`

## Requirements
- R1: While reset is active and on release, `seq_state` is 0 (unarmed), `pd_enable` is 1, `bo_request` is 0 and `nbw_eff` equals `nbw_pin`.
- R2: In the unarmed state (code 0) loss-of-lock edges are ignored. The sequencer moves to armed (code 1) on the first clock at which `lol` is low, and only then.
- R3: In armed (code 1), a clock at which `lol` is high after being low one clock earlier moves the sequencer to gate (code 2) on the next cycle. In gate, `pd_enable` is 0 and `nbw_eff` is 1.
- R4: From gate, with `bo_enable` high the sequencer enters build-out (code 3), holding `bo_request` at 1 and `pd_enable` at 0 until a clock with `bo_done` high. With `bo_enable` low it goes straight to track (code 4). `bo_request` is 1 only in build-out.
- R5: In track (code 4) and hold (code 5), `pd_enable` is 1.
- R6: In track, each clock with `cmp_valid` high and `cmp_in_window` high counts one in-window comparison. A clock with `cmp_valid` high and `cmp_in_window` low clears the count. Clocks with `cmp_valid` low neither count nor clear. The `RUN_LEN`-th consecutive in-window comparison moves the sequencer to hold (code 5) on the next cycle.
- R7: Hold lasts exactly `HOLD_CYCLES` clock cycles, after which the sequencer returns to armed (code 1).
- R8: `nbw_eff` is 1 in states 2 to 5 whatever `nbw_pin` is. In states 0 and 1 it follows `nbw_pin`.
- R9: A loss-of-lock edge during states 2 to 5 neither restarts nor shortens the recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lol | input | 1 | Loss-of-lock flag, high when out of lock |
| cmp_valid | input | 1 | One lock comparison completed this clock |
| cmp_in_window | input | 1 | That comparison was inside the phase window |
| nbw_pin | input | 1 | External narrow-bandwidth request |
| bo_enable | input | 1 | Feedback phase build-out enabled |
| bo_done | input | 1 | Build-out realignment finished |
| pd_enable | output | 1 | Phase detector in the loop |
| nbw_eff | output | 1 | Effective narrow-bandwidth control |
| bo_request | output | 1 | Request for feedback phase build-out |
| seq_state | output | 3 | Sequencer state code (0 unarmed, 1 armed, 2 gate, 3 build-out, 4 track, 5 hold) |

## Verification
The bench builds the block with `RUN_LEN` = 8, matching the eight-comparison run, and with `HOLD_CYCLES` = 6. The short hold lets a single run pass through many complete recoveries, so that re-arming, repeated triggers and the exact hold length are each exercised several times. Keeping the full run length means the broken-run case is tested at its real size: seven good comparisons, then a miss, then a fresh count.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;
  typedef enum logic [2:0] {
    ST_UNARMED = 3'd0,
    ST_ARMED   = 3'd1,
    ST_GATE    = 3'd2,
    ST_BUILD   = 3'd3,
    ST_TRACK   = 3'd4,
    ST_HOLD    = 3'd5
  } seq_state_e;

  function automatic logic is_active(seq_state_e s);
    return (s == ST_GATE) || (s == ST_BUILD) || (s == ST_TRACK) || (s == ST_HOLD);
  endfunction
endpackage

// File: rtl/hs_reset_sync.sv
module hs_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/hs_run_counter.sv
module hs_run_counter #(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  input  logic cmp_valid,
  input  logic cmp_in_window,
  output logic run_done
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] cnt_q, cnt_d;
  logic             hit;

  assign hit      = count_en && cmp_valid && cmp_in_window;
  assign run_done = hit && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!count_en)                   cnt_d = '0;
    else if (cmp_valid && !cmp_in_window) cnt_d = '0;
    else if (run_done)               cnt_d = '0;
    else if (hit)                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hs_hold_timer.sv
module hs_hold_timer #(
  parameter int HOLD_CYCLES = 44
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic expire
);
  localparam int TMR_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [TMR_W-1:0] LAST = TMR_W'(HOLD_CYCLES - 1);

  logic [TMR_W-1:0] tmr_q, tmr_d;

  assign expire = run_en && (tmr_q == LAST);

  always_comb begin
    tmr_d = tmr_q;
    if (!run_en)     tmr_d = '0;
    else if (expire) tmr_d = '0;
    else             tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end
endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
  import hs_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lol,
  input  logic       bo_enable,
  input  logic       bo_done,
  input  logic       run_done,
  input  logic       hold_expire,
  output seq_state_e state,
  output logic       lol_rise
);
  seq_state_e state_q, state_d;
  logic       lol_q;

  assign lol_rise = lol && !lol_q;
  assign state    = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_UNARMED: if (!lol)       state_d = ST_ARMED;
      ST_ARMED:   if (lol_rise)   state_d = ST_GATE;
      ST_GATE:    state_d = bo_enable ? ST_BUILD : ST_TRACK;
      ST_BUILD:   if (bo_done)    state_d = ST_TRACK;
      ST_TRACK:   if (run_done)   state_d = ST_HOLD;
      ST_HOLD:    if (hold_expire) state_d = ST_ARMED;
      default:    state_d = ST_UNARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_UNARMED;
      lol_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      lol_q   <= lol;
    end
  end
endmodule

// File: rtl/hitless_bw_seq.sv
module hitless_bw_seq
  import hs_seq_pkg::*;
#(
  parameter int RUN_LEN     = 8,
  parameter int HOLD_CYCLES = 44
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lol,
  input  logic       cmp_valid,
  input  logic       cmp_in_window,
  input  logic       nbw_pin,
  input  logic       bo_enable,
  input  logic       bo_done,
  output logic       pd_enable,
  output logic       nbw_eff,
  output logic       bo_request,
  output logic [2:0] seq_state
);
  logic       rst_n_int;
  logic       run_done;
  logic       hold_expire;
  logic       lol_rise;
  seq_state_e state;

  hs_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  hs_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .lol         (lol),
    .bo_enable   (bo_enable),
    .bo_done     (bo_done),
    .run_done    (run_done),
    .hold_expire (hold_expire),
    .state       (state),
    .lol_rise    (lol_rise)
  );

  hs_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .count_en      (state == ST_TRACK),
    .cmp_valid     (cmp_valid),
    .cmp_in_window (cmp_in_window),
    .run_done      (run_done)
  );

  hs_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .run_en (state == ST_HOLD),
    .expire (hold_expire)
  );

  logic unused_rise;
  assign unused_rise = lol_rise;

  assign pd_enable  = !((state == ST_GATE) || (state == ST_BUILD));
  assign bo_request = (state == ST_BUILD);
  assign nbw_eff    = nbw_pin || is_active(state);
  assign seq_state  = state;
endmodule

// File: rtl/hitless_bw_seq_checker.sv
module hitless_bw_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       lol,
  input logic       cmp_valid,
  input logic       nbw_pin,
  input logic       pd_enable,
  input logic       nbw_eff,
  input logic       bo_request,
  input logic [2:0] seq_state
);
  // R3: armed plus a rising loss-of-lock edge leads to gate
  a_r3_trigger_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd1 && lol && !$past(lol)) |=> (seq_state == 3'd2));

  // R4: build-out request never overlaps an enabled phase detector
  a_r4_req_gates_pd: assert property (@(posedge clk) disable iff (!rst_n)
    bo_request |-> !pd_enable);

  // R5: phase detector in the loop during track
  a_r5_track_pd_on: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd4) |-> pd_enable);

  // R8: forced narrow bandwidth during recovery
  a_r8_forced_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state >= 3'd2 && seq_state <= 3'd5) |-> nbw_eff);

  // R8: pin passes through when idle
  a_r8_pin_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state <= 3'd1) |-> (nbw_eff == nbw_pin));

  // R2: unarmed can only stay or arm
  a_r2_unarmed_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd0) |=> (seq_state <= 3'd1));

  // R7: hold exits only to armed
  a_r7_hold_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd5) |=> (seq_state == 3'd5 || seq_state == 3'd1));

  // R6: no progress out of track without a comparison
  a_r6_track_needs_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd4 && !cmp_valid) |=> (seq_state == 3'd4));
endmodule

bind hitless_bw_seq hitless_bw_seq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lol        (lol),
  .cmp_valid  (cmp_valid),
  .nbw_pin    (nbw_pin),
  .pd_enable  (pd_enable),
  .nbw_eff    (nbw_eff),
  .bo_request (bo_request),
  .seq_state  (seq_state)
);

// File: tb/sim_hitless_bw_seq.sv
module sim_hitless_bw_seq;
  localparam int RL = 8;
  localparam int HC = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, lol, cmp_valid, cmp_in_window, nbw_pin, bo_enable, bo_done;
  logic pd_enable, nbw_eff, bo_request;
  logic [2:0] seq_state;

  hitless_bw_seq #(.RUN_LEN(RL), .HOLD_CYCLES(HC)) u0 (
    .clk(clk), .rst_n(rst_n), .lol(lol), .cmp_valid(cmp_valid),
    .cmp_in_window(cmp_in_window), .nbw_pin(nbw_pin), .bo_enable(bo_enable),
    .bo_done(bo_done), .pd_enable(pd_enable), .nbw_eff(nbw_eff),
    .bo_request(bo_request), .seq_state(seq_state)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  int m_st, m_run, m_tmr;
  logic m_lolq;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string st_tag(int s);
    case (s)
      0: return "R2 state";
      1: return "R9 state";
      2: return "R3 state";
      3: return "R4 state";
      4: return "R6 state";
      default: return "R7 state";
    endcase
  endfunction

  function automatic int exp_pd(int s);
    return (s == 2 || s == 3) ? 0 : 1;
  endfunction

  function automatic int exp_nbw(int s, logic pin);
    return (s >= 2) ? 1 : int'(pin);
  endfunction

  task automatic compare_all();
    check(st_tag(m_st), int'(seq_state), m_st);
    check("R5 pd_enable", int'(pd_enable), exp_pd(m_st));
    check("R8 nbw_eff", int'(nbw_eff), exp_nbw(m_st, nbw_pin));
    check("R4 bo_request", int'(bo_request), (m_st == 3) ? 1 : 0);
  endtask

  // apply inputs at a falling edge, advance one clock, compare at the next falling edge
  task automatic step(logic l, logic be, logic bd, logic cv, logic cw, logic np);
    int ns, nr, nt;
    lol = l; bo_enable = be; bo_done = bd; cmp_valid = cv; cmp_in_window = cw; nbw_pin = np;
    ns = m_st; nr = m_run; nt = m_tmr;
    case (m_st)
      0: if (!l) ns = 1;
      1: if (l && !m_lolq) ns = 2;
      2: ns = be ? 3 : 4;
      3: if (bd) ns = 4;
      4: begin
        if (cv) begin
          if (cw) begin
            if (m_run == RL - 1) begin ns = 5; nr = 0; end
            else nr = m_run + 1;
          end else nr = 0;
        end
      end
      default: begin
        if (m_tmr == HC - 1) begin ns = 1; nt = 0; end
        else nt = m_tmr + 1;
      end
    endcase
    @(posedge clk);
    #1;
    m_st = ns; m_run = nr; m_tmr = nt; m_lolq = l;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hold_len;
    void'($urandom(32'd20417));
    rst_n = 1'b0; lol = 1'b1; cmp_valid = 1'b0; cmp_in_window = 1'b0;
    nbw_pin = 1'b1; bo_enable = 1'b0; bo_done = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state", int'(seq_state), 0);
    check("R1 reset pd_enable", int'(pd_enable), 1);
    check("R1 reset bo_request", int'(bo_request), 0);
    check("R1 reset nbw_eff pin high", int'(nbw_eff), 1);
    nbw_pin = 1'b0;
    #1;
    check("R1 reset nbw_eff pin low", int'(nbw_eff), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release state", int'(seq_state), 0);
    m_st = 0; m_run = 0; m_tmr = 0; m_lolq = 1'b1;

    // R2: loss of lock held high keeps it unarmed
    repeat (3) step(1, 0, 0, 1, 1, 0);
    check("R2 no arm while lol high", int'(seq_state), 0);
    step(0, 0, 0, 0, 0, 0);
    check("R2 arm on lock", int'(seq_state), 1);

    // R3: trigger without build-out
    step(1, 0, 0, 0, 0, 0);
    check("R3 gate state", int'(seq_state), 2);
    check("R3 gate pd off", int'(pd_enable), 0);
    check("R3 gate narrow", int'(nbw_eff), 1);
    step(1, 0, 0, 0, 0, 0);
    check("R4 skip build-out", int'(seq_state), 4);

    // R9: new loss-of-lock edge while tracking
    step(0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    check("R9 edge ignored in track", int'(seq_state), 4);

    // R6: seven in-window, one miss, then a fresh run with gaps
    for (int i = 0; i < 7; i++) step(0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0, 0);
    check("R6 miss clears run", int'(seq_state), 4);
    for (int i = 0; i < 7; i++) begin
      step(0, 0, 0, 1, 1, 0);
      step(0, 0, 0, 0, 0, 0);
    end
    check("R6 seven after reset still track", int'(seq_state), 4);
    step(0, 0, 0, 1, 1, 1);
    check("R6 eighth enters hold", int'(seq_state), 5);
    check("R8 narrow forced over pin low", int'(nbw_eff), 1);

    // R7: hold length
    hold_len = 1;
    for (int i = 0; i < 3 * HC && seq_state == 3'd5; i++) begin
      step(i == 1, 0, 0, 0, 0, 0);
      if (seq_state == 3'd5) hold_len++;
    end
    check("R7 hold length", hold_len, HC);
    check("R7 back to armed", int'(seq_state), 1);
    step(0, 0, 0, 0, 0, 1);
    check("R8 pin high passes", int'(nbw_eff), 1);
    step(0, 0, 0, 0, 0, 0);
    check("R8 pin low passes", int'(nbw_eff), 0);

    // R4: build-out path
    step(1, 1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    check("R4 build-out state", int'(seq_state), 3);
    repeat (3) step(1, 1, 0, 0, 0, 0);
    check("R4 request held", int'(bo_request), 1);
    check("R4 pd off while building", int'(pd_enable), 0);
    step(1, 1, 1, 0, 0, 0);
    check("R5 track after done", int'(pd_enable), 1);
    check("R4 request dropped", int'(bo_request), 0);

    // constrained random phase, compared against the model every cycle
    for (int c = 0; c < 3000; c++) begin
      logic rl, rbe, rbd, rcv, rcw, rnp;
      rl  = (($urandom % 12) == 0);
      rbe = ((c / 200) % 2) == 1;
      rbd = (($urandom % 4) == 0);
      rcv = (($urandom % 2) == 0);
      rcw = (($urandom % 10) != 0);
      rnp = (($urandom % 8) == 0);
      step(rl, rbe, rbd, rcv, rcw, rnp);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule